// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block sinks message-signalled interrupts that reach the chip as inbound memory writes. Every inbound write carries a 64-bit address and a 32-bit data word. When the address equals a 64-bit target that software has programmed, the data word is taken as a flat vector number. That vector selects one status bit in a bank of 32-bit vector groups. Each group holds three words: an enable word, a mask word and a status word.

Software reaches the target address and the group registers through a simple 32-bit register port. Read data comes back one cycle after the read strobe. Software clears a pending status bit by writing a 1 to it. One interrupt output goes high while any vector is pending, enabled and unmasked. The block takes no part in how vectors are handed out, how inbound packets are parsed, or how the interrupt is routed further.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq_out` is low. This covers the target address words and all enable, mask and status words.
- R2: The target address low word is read/write at offset 0x820 and the high word at offset 0x824. Both are full 32-bit words.
- R3: Group g (g = 0..7) has its enable word at 0x828 + 12*g, its mask word at 0x82C + 12*g and its status word at 0x830 + 12*g. Enable and mask are plain read/write words.
- R4: An inbound write whose 64-bit address equals {high word, low word} and whose data v is below 256 sets bit v%32 of group v/32, provided that bit is enabled. An inbound write to any other address changes nothing.
- R5: An inbound write that hits the target address with data of 256 or more changes no status bit.
- R6: A vector whose enable bit is clear at the time of the inbound write is not recorded and does not raise `irq_out`.
- R7: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged. A register write never sets a status bit.
- R8: If an inbound write sets a status bit in the same cycle as a register write clears that bit, the bit ends up set.
- R9: `irq_out` is high exactly when some status bit is set, its enable bit is set and its mask bit is clear. A masked vector is still recorded in status.
- R10: A read of any offset that is not defined above returns zero, and this includes unaligned offsets. A write to such an offset changes no register.
- R11: `reg_rdata` shows the addressed word in the cycle after `reg_rd_en` is sampled high, and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data (vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The bench checks vector 255, the last valid vector, and vector 256, the first invalid one. A design with an off-by-one range check would either drop the top vector or wrap 256 onto vector 0. It checks a same-cycle set and clear on one bit; a design that gives priority to the clear would lose that interrupt. It writes zeros to a status word, which a design that treats the status word as plain read/write would wipe. It also sends a hit on a disabled vector, a write to a near-miss address, and reads and writes at unaligned offsets and just past the last group. A design with loose decoding would record these, or alias them onto real registers.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/100ps
// Package: shared register offsets and widths for the MSI capture block.
// Assumes a byte-addressed register port with word-aligned registers.
package msi_cap_pkg;

    localparam int unsigned REG_AW      = 12;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned VEC_PER_GRP = 32;

    localparam logic [REG_AW-1:0] OFF_TGT_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFF_TGT_HI = 12'h824;
    localparam int unsigned       OFF_GRP0   = 32'h828;
    localparam int unsigned       GRP_STRIDE = 12;

    // Field order inside one group's triple.
    typedef enum logic [1:0] {
        FLD_ENABLE = 2'd0,
        FLD_MASK   = 2'd1,
        FLD_STATUS = 2'd2
    } grp_field_e;

    // Byte offset of one field of one group.
    function automatic logic [REG_AW-1:0] grp_offset(input int unsigned g,
                                                     input grp_field_e f);
        int unsigned off;
        off = OFF_GRP0 + GRP_STRIDE * g + 4 * int'(f);
        return off[REG_AW-1:0];
    endfunction

endpackage

// File: rtl/msi_cap_regdec.sv
`timescale 1ns/100ps
// Module: register offset decoder.
// Turns a byte offset into one-hot selects for the target words and
// for each group's enable, mask and status word. Each select is an exact
// compare, so unaligned or unused offsets select nothing.
module msi_cap_regdec
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8
) (
    input  logic [REG_AW-1:0]     addr,
    output logic                  sel_tgt_lo,
    output logic                  sel_tgt_hi,
    output logic [NUM_GROUPS-1:0] sel_en,
    output logic [NUM_GROUPS-1:0] sel_mask,
    output logic [NUM_GROUPS-1:0] sel_stat
);

    // Target address word selects.
    assign sel_tgt_lo = (addr == OFF_TGT_LO);
    assign sel_tgt_hi = (addr == OFF_TGT_HI);

    // One compare per group field; the offsets come from the stride.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [REG_AW-1:0] EN_OFF   = grp_offset(g, FLD_ENABLE);
        localparam logic [REG_AW-1:0] MASK_OFF = grp_offset(g, FLD_MASK);
        localparam logic [REG_AW-1:0] STAT_OFF = grp_offset(g, FLD_STATUS);
        assign sel_en[g]   = (addr == EN_OFF);
        assign sel_mask[g] = (addr == MASK_OFF);
        assign sel_stat[g] = (addr == STAT_OFF);
    end

endmodule

// File: rtl/msi_cap_hitdec.sv
`timescale 1ns/100ps
// Module: inbound write hit detector and vector decoder.
// Compares the inbound 64-bit address with the programmed target. On a hit
// whose data is a valid vector number it raises one bit of a flat set
// vector. Out-of-range data raises nothing.
module msi_cap_hitdec #(
    parameter int unsigned NUM_VEC = 256,
    localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
    input  logic               in_wr_valid,
    input  logic [63:0]        in_wr_addr,
    input  logic [31:0]        in_wr_data,
    input  logic [63:0]        target_addr,
    output logic [NUM_VEC-1:0] set_flat
);

    logic             addr_match;
    logic             data_ok;
    logic [VEC_W-1:0] vec_idx;

    // Qualify the write: valid, exact address and in-range vector.
    assign addr_match = in_wr_valid && (in_wr_addr == target_addr);
    assign data_ok    = (in_wr_data < 32'(NUM_VEC));
    assign vec_idx    = in_wr_data[VEC_W-1:0];

    // Produce a one-hot set pulse for the selected flat vector.
    always_comb begin
        set_flat = '0;
        if (addr_match && data_ok) begin
            set_flat[vec_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/msi_cap_group.sv
`timescale 1ns/100ps
// Module: one vector group holding enable, mask and status words.
// Status bits are set only for enabled vectors and are cleared by writing
// a 1. A set wins over a clear of the same bit in the same cycle.
// Assumes at most one register write per cycle.
module msi_cap_group #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_word,
    input  logic         wr_mask_word,
    input  logic         wr_stat_word,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] enable_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] status_q,
    output logic         pend
);

    logic [W-1:0] clr_bits;
    logic [W-1:0] gated_set;

    // Clear pattern from a status write; gated set from enables.
    assign clr_bits  = wr_stat_word ? wdata : '0;
    assign gated_set = set_bits & enable_q;

    // Enable word register.
    always_ff @(posedge clk) begin
        if (!rst_n)          enable_q <= '0;
        else if (wr_en_word) enable_q <= wdata;
    end

    // Mask word register.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '0;
        else if (wr_mask_word) mask_q <= wdata;
    end

    // Status word: write-1-to-clear, then set on top so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | gated_set;
    end

    // Group-level pending flag: recorded, enabled and not masked.
    assign pend = |(status_q & enable_q & ~mask_q);

endmodule

// File: rtl/msi_capture_ctrl.sv
`timescale 1ns/100ps
// Module: MSI capture interrupt controller (top).
// Holds the 64-bit target address, instantiates the vector groups,
// decodes register accesses, returns read data one cycle after a read
// strobe and drives the combined interrupt. Assumes reg_wr_en and
// reg_rd_en are not asserted in the same cycle.
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_wr_valid,
    input  logic [63:0]       in_wr_addr,
    input  logic [31:0]       in_wr_data,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out
);

    localparam int unsigned NUM_VEC = NUM_GROUPS * VEC_PER_GRP;

    logic [31:0]           tgt_lo_q;
    logic [31:0]           tgt_hi_q;
    logic                  sel_tgt_lo;
    logic                  sel_tgt_hi;
    logic [NUM_GROUPS-1:0] sel_en;
    logic [NUM_GROUPS-1:0] sel_mask;
    logic [NUM_GROUPS-1:0] sel_stat;
    logic [NUM_VEC-1:0]    set_flat;
    logic [NUM_VEC-1:0]    status_flat;
    logic [NUM_VEC-1:0]    en_flat;
    logic [NUM_GROUPS-1:0] grp_pend;
    logic [31:0]           grp_en   [NUM_GROUPS];
    logic [31:0]           grp_mask [NUM_GROUPS];
    logic [31:0]           grp_stat [NUM_GROUPS];
    logic [31:0]           rd_val;

    // Register offset decode.
    msi_cap_regdec #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_regdec (
        .addr       (reg_addr),
        .sel_tgt_lo (sel_tgt_lo),
        .sel_tgt_hi (sel_tgt_hi),
        .sel_en     (sel_en),
        .sel_mask   (sel_mask),
        .sel_stat   (sel_stat)
    );

    // Inbound write match and vector decode.
    msi_cap_hitdec #(
        .NUM_VEC (NUM_VEC)
    ) u_hitdec (
        .in_wr_valid (in_wr_valid),
        .in_wr_addr  (in_wr_addr),
        .in_wr_data  (in_wr_data),
        .target_addr ({tgt_hi_q, tgt_lo_q}),
        .set_flat    (set_flat)
    );

    // Target address low word.
    always_ff @(posedge clk) begin
        if (!rst_n)                       tgt_lo_q <= '0;
        else if (reg_wr_en && sel_tgt_lo) tgt_lo_q <= reg_wdata;
    end

    // Target address high word.
    always_ff @(posedge clk) begin
        if (!rst_n)                       tgt_hi_q <= '0;
        else if (reg_wr_en && sel_tgt_hi) tgt_hi_q <= reg_wdata;
    end

    // One group per 32 vectors.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        msi_cap_group #(
            .W (VEC_PER_GRP)
        ) u_group (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en_word   (reg_wr_en && sel_en[g]),
            .wr_mask_word (reg_wr_en && sel_mask[g]),
            .wr_stat_word (reg_wr_en && sel_stat[g]),
            .wdata        (reg_wdata),
            .set_bits     (set_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
            .enable_q     (grp_en[g]),
            .mask_q       (grp_mask[g]),
            .status_q     (grp_stat[g]),
            .pend         (grp_pend[g])
        );
        assign status_flat[g*VEC_PER_GRP +: VEC_PER_GRP] = grp_stat[g];
        assign en_flat[g*VEC_PER_GRP +: VEC_PER_GRP]     = grp_en[g];
    end

    // Read mux: OR of the selected words; no select gives zero.
    always_comb begin
        rd_val = '0;
        if (sel_tgt_lo) rd_val = rd_val | tgt_lo_q;
        if (sel_tgt_hi) rd_val = rd_val | tgt_hi_q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel_en[g])   rd_val = rd_val | grp_en[g];
            if (sel_mask[g]) rd_val = rd_val | grp_mask[g];
            if (sel_stat[g]) rd_val = rd_val | grp_stat[g];
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_val;
    end

    // Combined interrupt output.
    assign irq_out = |grp_pend;

endmodule

// File: rtl/msi_capture_chk.sv
`timescale 1ns/100ps
// Module: assertion checker for msi_capture_ctrl, attached by bind.
// Watches the ports and the flat status/enable vectors over time.
module msi_capture_chk #(
    parameter int unsigned NUM_VEC = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_wr_valid,
    input logic [31:0]        in_wr_data,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [31:0]        reg_rdata,
    input logic               irq_out,
    input logic [NUM_VEC-1:0] status_flat,
    input logic [NUM_VEC-1:0] en_flat
);

    // R4: a status bit rises only after an inbound write.
    p_set_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_flat & ~$past(status_flat))) |-> $past(in_wr_valid));

    // R5: out-of-range vector data sets nothing.
    p_oor_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wr_valid && (in_wr_data >= 32'(NUM_VEC)))
        |=> ((status_flat & ~$past(status_flat)) == '0));

    // R6: a bit that was disabled never becomes recorded.
    p_disabled_not_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & ~$past(status_flat) & ~$past(en_flat)) == '0));

    // R7: a status bit falls only after a register write.
    p_clear_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_flat) & ~status_flat)) |-> $past(reg_wr_en));

    // R9: the interrupt requires an enabled recorded vector.
    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(status_flat & en_flat)));

    // R11: read data holds while no read was issued.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_rd_en)) |-> $stable(reg_rdata));

endmodule

bind msi_capture_ctrl msi_capture_chk #(
    .NUM_VEC (NUM_GROUPS * 32)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_wr_valid (in_wr_valid),
    .in_wr_data  (in_wr_data),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_rdata   (reg_rdata),
    .irq_out     (irq_out),
    .status_flat (status_flat),
    .en_flat     (en_flat)
);

// File: tb/tb_msi_capture_ctrl.sv
`timescale 1ns/100ps
// Bench: table-driven walk over the main function, then directed tests
// for reset, same-cycle set/clear and reset in mid-run.
module tb_msi_capture_ctrl;

    localparam logic [1:0] OP_W = 2'd0;  // register write
    localparam logic [1:0] OP_R = 2'd1;  // register read, compare rdata
    localparam logic [1:0] OP_M = 2'd2;  // inbound memory write
    localparam logic [1:0] OP_I = 2'd3;  // compare irq_out with exp[0]

    localparam logic [63:0] TGT = 64'h0000_0012_FEE0_1000;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 64'h820, 32'hFEE0_1000, 32'h0, 4'd2},          // R2
        '{OP_W, 64'h824, 32'h0000_0012, 32'h0, 4'd2},          // R2
        '{OP_R, 64'h820, 32'h0, 32'hFEE0_1000, 4'd2},          // R2
        '{OP_R, 64'h824, 32'h0, 32'h0000_0012, 4'd2},          // R2
        '{OP_W, 64'h828, 32'h0000_0021, 32'h0, 4'd3},          // R3 group 0 enable
        '{OP_W, 64'h87C, 32'h8000_0000, 32'h0, 4'd3},          // R3 group 7 enable
        '{OP_R, 64'h87C, 32'h0, 32'h8000_0000, 4'd3},          // R3
        '{OP_R, 64'h828, 32'h0, 32'h0000_0021, 4'd3},          // R3
        '{OP_M, TGT,     32'd5, 32'h0, 4'd4},                  // R4 vector 5
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd4},          // R4
        '{OP_I, 64'h0,   32'h0, 32'h1, 4'd9},                  // R9
        '{OP_M, TGT,     32'd3, 32'h0, 4'd6},                  // R6 disabled vector
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd6},          // R6
        '{OP_M, TGT + 64'd4, 32'd0, 32'h0, 4'd4},              // R4 address miss
        '{OP_M, TGT ^ 64'h1_0000_0000, 32'd5, 32'h0, 4'd4},    // R4 high word miss
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd4},          // R4
        '{OP_M, TGT,     32'd256, 32'h0, 4'd5},                // R5 first invalid
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd5},          // R5 no wrap to 0
        '{OP_R, 64'h884, 32'h0, 32'h0, 4'd5},                  // R5
        '{OP_M, TGT,     32'd255, 32'h0, 4'd4},                // R4 last vector
        '{OP_R, 64'h884, 32'h0, 32'h8000_0000, 4'd4},          // R4
        '{OP_W, 64'h82C, 32'h0000_0020, 32'h0, 4'd9},          // R9 mask vector 5
        '{OP_I, 64'h0,   32'h0, 32'h1, 4'd9},                  // R9 vector 255 still live
        '{OP_W, 64'h880, 32'h8000_0000, 32'h0, 4'd9},          // R9 mask vector 255
        '{OP_I, 64'h0,   32'h0, 32'h0, 4'd9},                  // R9
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd9},          // R9 masked still recorded
        '{OP_W, 64'h830, 32'h0, 32'h0, 4'd7},                  // R7 write zeros
        '{OP_R, 64'h830, 32'h0, 32'h0000_0020, 4'd7},          // R7
        '{OP_W, 64'h830, 32'h0000_0020, 32'h0, 4'd7},          // R7 write one
        '{OP_R, 64'h830, 32'h0, 32'h0, 4'd7},                  // R7
        '{OP_R, 64'h826, 32'h0, 32'h0, 4'd10},                 // R10 unaligned
        '{OP_R, 64'h888, 32'h0, 32'h0, 4'd10},                 // R10 past last group
        '{OP_R, 64'h000, 32'h0, 32'h0, 4'd10}                  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_wr_valid = 1'b0;
    logic [63:0] in_wr_addr = '0;
    logic [31:0] in_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    msi_capture_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_wr_valid (in_wr_valid),
        .in_wr_addr  (in_wr_addr),
        .in_wr_data  (in_wr_data),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_out     (irq_out)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic msi_write(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d;
        @(negedge clk);
        in_wr_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1: reset state of target, group words and interrupt.
        reg_read(12'h820, rd); check(1, rd, 32'h0);
        reg_read(12'h824, rd); check(1, rd, 32'h0);
        reg_read(12'h828, rd); check(1, rd, 32'h0);
        reg_read(12'h82C, rd); check(1, rd, 32'h0);
        reg_read(12'h884, rd); check(1, rd, 32'h0);
        check(1, {31'h0, irq_out}, 32'h0);

        // R11: rdata holds with no read strobe.
        reg_write(12'h828, 32'h1234_5678);
        reg_read(12'h828, rd);
        @(negedge clk); @(negedge clk);
        check(11, reg_rdata, 32'h1234_5678);
        reg_write(12'h828, 32'h0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_W: reg_write(TBL[i].addr[11:0], TBL[i].data);
                OP_R: begin
                    reg_read(TBL[i].addr[11:0], rd);
                    check(int'(TBL[i].req), rd, TBL[i].exp);
                end
                OP_M: msi_write(TBL[i].addr, TBL[i].data);
                default: check(int'(TBL[i].req), {31'h0, irq_out}, TBL[i].exp);
            endcase
        end

        // R10: write to an undefined offset changes nothing.
        reg_write(12'h888, 32'hFFFF_FFFF);
        reg_write(12'h82A, 32'hFFFF_FFFF);
        reg_read(12'h828, rd); check(10, rd, 32'h0000_0021);
        reg_read(12'h884, rd); check(10, rd, 32'h8000_0000);

        // R8: set and clear of vector 34 (group 1 bit 2) in one cycle.
        reg_write(12'h834, 32'h0000_0004);
        msi_write(TGT, 32'd34);
        @(negedge clk);
        in_wr_valid = 1'b1; in_wr_addr = TGT; in_wr_data = 32'd34;
        reg_wr_en = 1'b1; reg_addr = 12'h83C; reg_wdata = 32'h0000_0004;
        @(negedge clk);
        in_wr_valid = 1'b0; reg_wr_en = 1'b0;
        reg_read(12'h83C, rd); check(8, rd, 32'h0000_0004);
        check(9, {31'h0, irq_out}, 32'h1);
        reg_write(12'h83C, 32'h0000_0004);
        reg_read(12'h83C, rd); check(7, rd, 32'h0);

        // R1: reset in mid-run clears everything.
        do_reset();
        check(1, {31'h0, irq_out}, 32'h0);
        reg_read(12'h820, rd); check(1, rd, 32'h0);
        reg_read(12'h884, rd); check(1, rd, 32'h0);
        reg_read(12'h87C, rd); check(1, rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule